// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Chain

This block is a row of interrupt stages wired head to tail, each holding one pending interrupt and one fixed vector number. A stage passes a "request" signal down to the next one. A stage with nothing pending forwards what it receives. A stage with something pending forces the signal true. The signal leaving the tail stage is the single interrupt request seen by the processor.

When the processor runs an acknowledge cycle, exactly one stage owns the vector bus. That stage is the one that has a pending request and receives a false signal from the stage above it. This is always the pending stage nearest the head. No central arbiter is involved, so priority comes only from where a stage sits in the row.

The winning stage drops its pending request at the end of the acknowledge cycle. The next acknowledge then serves the next stage down the row.

Top module: `irq_daisy_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every stage's pending request is cleared. After reset, `int_req` is 0, `vec_valid` is 0, `stage_drive` is 0 and `vec_out` is 0.
- R2: A high level on `irq_in[i]` at a rising edge makes stage i pending. From then on `int_req` is 1, and it stays 1 until that stage has been acknowledged.
- R3: A stage with nothing pending passes the chain signal through unchanged, so `int_req` equals the OR of all pending requests. It is 0 when none is pending.
- R4: In a cycle with `ack`=1, only the pending stage with the lowest index drives. Index 0 is the head of the chain. That stage's bit in `stage_drive` is 1, `vec_valid` is 1, and `vec_out` equals VEC_BASE + i*VEC_STEP (defaults 8'h40 and 4).
- R5: In a cycle with `ack`=0, no stage drives: `stage_drive` is 0, `vec_valid` is 0 and `vec_out` is 0.
- R6: At the end of an acknowledge cycle, only the driving stage's pending request is cleared. All other pending requests remain.
- R7: If `irq_in[i]` is high in the same cycle that stage i is acknowledged, stage i stays pending. Setting takes precedence over clearing.
- R8: An acknowledge with nothing pending gives `vec_valid`=0 and `vec_out`=0, and it changes no state.
- R9: At most one bit of `stage_drive` is ever 1.
- R10: A request that arrives during an acknowledge cycle does not take part in that cycle's selection, even if it sits nearer the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_STAGES | Request inputs; bit i sets stage i pending |
| ack | input | 1 | Processor acknowledge cycle |
| int_req | output | 1 | Combined request: the chain signal leaving the tail stage |
| vec_out | output | VEC_W | Vector on the shared bus; 0 when nobody drives |
| vec_valid | output | 1 | Some stage drives the bus this cycle |
| stage_drive | output | N_STAGES | Per-stage bus-drive enables |

## Verification
The hardest situation to reach is a deep chain in which several stages are pending together. In that state the winner depends on every stage above it forwarding a false signal, and each acknowledge must peel off exactly one stage. The bench loads every one of the 256 pending patterns of the eight-stage default and then drains each pattern with repeated acknowledges, checking the winner and the vector at every step. Two directed cases cover the remaining races. In one, a request is raised at the stage being cleared. In the other, a request arrives nearer the head during an acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int DEF_STAGES   = 8;
    localparam int DEF_VEC_W    = 8;
    localparam int DEF_VEC_BASE = 8'h40;
    localparam int DEF_VEC_STEP = 4;

    // Per-stage chain status, carried between stage and top
    typedef struct packed {
        logic pend;    // latched request
        logic cout;    // chain signal toward the tail
        logic win;     // this stage owns the bus if acknowledged
    } stage_stat_t;

    // Vector number held by stage idx
    function automatic int unsigned stage_vector(int unsigned base,
                                                 int unsigned step,
                                                 int unsigned idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
    import irq_chain_pkg::*;
#(
    parameter int          VEC_W = DEF_VEC_W,
    parameter logic [VEC_W-1:0] VEC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_set,
    input  logic             ack,
    input  logic             chain_in,
    output stage_stat_t      stat,
    output logic             drive,
    output logic [VEC_W-1:0] vec_drv
);

    logic pend_q;

    // Combinational chain rules: pass-through when idle, force when pending
    always_comb begin
        stat.pend = pend_q;
        stat.cout = pend_q | chain_in;
        stat.win  = stat.cout & ~chain_in;
        drive     = ack & stat.win;
        vec_drv   = drive ? VEC : '0;
    end

    // Request latch: set has precedence over the acknowledge clear
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (req_set)
            pend_q <= 1'b1;
        else if (drive)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/irq_vec_combine.sv
module irq_vec_combine #(
    parameter int N_STAGES = 8,
    parameter int VEC_W    = 8
) (
    input  logic [N_STAGES-1:0][VEC_W-1:0] vec_drv,
    input  logic [N_STAGES-1:0]            drive,
    output logic [VEC_W-1:0]               vec_bus,
    output logic                           bus_valid
);

    // Wired-OR bus: idle stages drive zeros
    always_comb begin
        vec_bus = '0;
        for (int i = 0; i < N_STAGES; i++)
            vec_bus = vec_bus | vec_drv[i];
        bus_valid = |drive;
    end

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int N_STAGES = DEF_STAGES,
    parameter int VEC_W    = DEF_VEC_W,
    parameter int VEC_BASE = DEF_VEC_BASE,
    parameter int VEC_STEP = DEF_VEC_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STAGES-1:0] irq_in,
    input  logic                ack,
    output logic                int_req,
    output logic [VEC_W-1:0]    vec_out,
    output logic                vec_valid,
    output logic [N_STAGES-1:0] stage_drive
);

    localparam int LAST = N_STAGES - 1;

    logic [N_STAGES:0]                chain;
    logic [N_STAGES-1:0][VEC_W-1:0]   vdrv;
    stage_stat_t [N_STAGES-1:0]       stat;
    logic [N_STAGES-1:0]              pending;

    assign chain[0] = 1'b0;   // head of chain sees no request above it

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        localparam logic [VEC_W-1:0] VEC_G =
            VEC_W'(stage_vector(VEC_BASE, VEC_STEP, g));
        irq_chain_stage #(.VEC_W(VEC_W), .VEC(VEC_G)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .req_set  (irq_in[g]),
            .ack      (ack),
            .chain_in (chain[g]),
            .stat     (stat[g]),
            .drive    (stage_drive[g]),
            .vec_drv  (vdrv[g])
        );
        assign chain[g+1]  = stat[g].cout;
        assign pending[g]  = stat[g].pend;
    end

    assign int_req = chain[LAST+1];

    irq_vec_combine #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_comb (
        .vec_drv   (vdrv),
        .drive     (stage_drive),
        .vec_bus   (vec_out),
        .bus_valid (vec_valid)
    );

endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
    parameter int N_STAGES = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [N_STAGES-1:0] irq_in,
    input logic                ack,
    input logic                int_req,
    input logic                vec_valid,
    input logic [N_STAGES-1:0] stage_drive,
    input logic [N_STAGES-1:0] pend
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pend == '0));

    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        (int_req && !ack) |=> int_req);

    p_chain_or_r3: assert property (@(posedge clk) disable iff (rst)
        int_req == (|pend));

    p_idle_nodrive_r5: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (stage_drive == '0 && !vec_valid));

    p_clear_winner_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> pend == (($past(pend) & ~$past(stage_drive)) | $past(irq_in)));

    p_empty_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_req) |-> !vec_valid);

    p_onehot_drive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_drive));

endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N_STAGES(N_STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_in      (irq_in),
    .ack         (ack),
    .int_req     (int_req),
    .vec_valid   (vec_valid),
    .stage_drive (stage_drive),
    .pend        (pending)
);

// File: tb/sim_irq_daisy_chain.sv
module sim_irq_daisy_chain;

    localparam int N  = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          ack = 1'b0;
    logic          int_req;
    logic [VW-1:0] vec_out;
    logic          vec_valid;
    logic [N-1:0]  stage_drive;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_daisy_chain u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack),
        .int_req(int_req), .vec_out(vec_out),
        .vec_valid(vec_valid), .stage_drive(stage_drive)
    );

    function automatic logic [VW-1:0] vec_of(int idx);
        return VW'(8'h40 + 4 * idx);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, then sample outputs 1 ns later
    task automatic drive_in(input logic [N-1:0] irq, input logic a);
        @(negedge clk);
        irq_in = irq;
        ack    = a;
        #1;
    endtask

    task automatic idle_checks();
        chk(int'(stage_drive), 0, "R5 drive idle");
        chk(int'(vec_out), 0, "R5 vector idle");
        chk(int'(vec_valid), 0, "R5 valid idle");
    endtask

    task automatic ack_expect(input int idx, input logic [N-1:0] irq);
        drive_in(irq, 1'b1);
        chk(int'(stage_drive), 1 << idx, "R4/R9 drive select");
        chk(int'(vec_out), int'(vec_of(idx)), "R4 vector");
        chk(int'(vec_valid), 1, "R4 valid");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        drive_in('0, 1'b0);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(int'(int_req), 0, "R1 int_req after reset");
        chk(int'(vec_valid), 0, "R1 valid after reset");
        chk(int'(stage_drive), 0, "R1 drive after reset");
        chk(int'(vec_out), 0, "R1 vector after reset");

        // Exhaustive sweep over all pending patterns, drained in priority order
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] rem;
            rem = N'(p);
            drive_in(N'(p), 1'b0);
            idle_checks();
            drive_in('0, 1'b0);
            chk(int'(int_req), int'(p != 0), "R2/R3 combined request");
            idle_checks();
            while (rem != '0) begin
                int low;
                low = 0;
                for (int k = N - 1; k >= 0; k--)
                    if (rem[k]) low = k;
                ack_expect(low, '0);
                rem[low] = 1'b0;
                drive_in('0, 1'b0);
                chk(int'(int_req), int'(rem != '0), "R6 remaining pending");
            end
            // R8: empty acknowledge
            drive_in('0, 1'b1);
            chk(int'(vec_valid), 0, "R8 empty ack valid");
            chk(int'(vec_out), 0, "R8 empty ack vector");
            drive_in('0, 1'b0);
            chk(int'(int_req), 0, "R8 still idle");
        end

        // R7: set during own clear keeps it pending
        drive_in(8'h08, 1'b0);
        ack_expect(3, 8'h08);
        drive_in('0, 1'b0);
        chk(int'(int_req), 1, "R7 set over clear");
        ack_expect(3, '0);
        drive_in('0, 1'b0);
        chk(int'(int_req), 0, "R7 drained");

        // R10: head request raised during ack of tail stage
        drive_in(8'h80, 1'b0);
        ack_expect(7, 8'h01);
        ack_expect(0, '0);
        drive_in('0, 1'b0);
        chk(int'(int_req), 0, "R10 drained");

        // R1: reset mid-run clears pending
        drive_in(8'h5A, 1'b0);
        rst = 1'b1;
        drive_in('0, 1'b0);
        rst = 1'b0;
        drive_in('0, 1'b0);
        chk(int'(int_req), 0, "R1 reset clears pending");

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule